// File: doc/BRIEF.md
# Eight-Instruction 32-bit Integer Core

This block is a compact processor core that runs a small subset of a 32-bit integer RISC instruction set. It executes register add, subtract, OR and AND, add-immediate, branch-if-equal, and word load and store. Its architectural state is thirty-two 32-bit registers, a program counter, and a 512-byte byte-addressed memory that holds both code and data. Every clock cycle in which `run` is high and the core has not stopped, it fetches, decodes and retires exactly one instruction.

The surrounding logic (in practice, the testbench) holds `run` low and writes a program image into memory one word at a time through the load port. It then raises `run` and waits for one of three stop flags. `done` means the program finished normally. The core has no halt instruction: it stops itself once it has fetched the fifth canonical NOP in an unbroken run. `illegal` means it met an encoding outside the supported set. `memErr` means an instruction fetch or a data access fell outside the 512 bytes. The debug ports read any register, any memory word and the program counter at any time, without affecting execution.

Top module: `mcore_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the program counter, all 32 registers, all 128 memory words and the three stop flags to zero.
- R2: Every retired instruction other than a taken branch advances the program counter by 4. beq (opcode 1100011, funct3 000) compares rs1 (bits 19:15) with rs2 (bits 24:20). When they are equal it adds a signed 13-bit offset, built from inst[31] as bit 12, inst[7] as bit 11, inst[30:25] as bits 10:5, inst[11:8] as bits 4:1, and a zero bit 0. When they differ it advances by 4.
- R3: Opcode 0110011 writes rd (bits 11:7) with rs1+rs2 for funct3 000 and funct7 (bits 31:25) 0000000; with rs1−rs2 for funct3 000 and funct7 0100000; with rs1|rs2 for funct3 110 and funct7 0000000; and with rs1&rs2 for funct3 111 and funct7 0000000.
- R4: addi (opcode 0010011, funct3 000) writes rd with rs1 plus inst[31:20] sign-extended from bit 11.
- R5: lw (opcode 0000011, funct3 010) loads the 32-bit word at byte address rs1 + sign-extended inst[31:20]. sw (opcode 0100011, funct3 010) stores rs2 at byte address rs1 + sign-extended {inst[31:25], inst[11:7]}. Word index is address bits 8:2, and addresses are assumed word aligned.
- R6: Writes to register 0 are discarded, and register 0 always reads as zero.
- R7: The canonical NOP is the word 0x00000013. On fetching it, the core retires it if fewer than four NOPs immediately precede it. On the fifth consecutive NOP it sets `done` and does not retire it, so the program counter stays at that NOP. Any other retired instruction restarts the count.
- R8: Once any stop flag is set, the program counter, registers, memory and flags stay unchanged while `run` remains high, until the next reset.
- R9: Any fetched word that is not a supported encoding and not the fifth NOP sets `illegal`. The word has no other effect and the program counter stays at its address.
- R10: An instruction fetch from a program counter above 511, or an lw/sw whose computed address (as an unsigned 32-bit value) is above 511, sets `memErr` without any register or memory write. The program counter stays put.
- R11: While `run` is low, the core does not step. A high `loadEn` at a clock edge writes `loadData` into memory word `loadIdx`. Debug reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Step enable; low allows program loading |
| loadEn | input | 1 | Memory load strobe (honoured while run is low) |
| loadIdx | input | 7 | Memory word index for loading |
| loadData | input | 32 | Word to load |
| dbgRegSel | input | 5 | Register number for debug read |
| dbgRegData | output | 32 | Value of the selected register |
| dbgMemIdx | input | 7 | Memory word index for debug read |
| dbgMemData | output | 32 | Value of the selected memory word |
| dbgPc | output | 32 | Current program counter |
| done | output | 1 | Stopped after the fifth consecutive NOP |
| illegal | output | 1 | Stopped on an unsupported encoding |
| memErr | output | 1 | Stopped on an out-of-range fetch or data address |

## Verification
Each instruction retires at the clock edge where it is fetched. Its register, memory, program-counter and stop-flag effects all appear together right after that edge, so every result is due exactly one edge after the cycle in which it is presented. The bench advances its behavioural model at that same edge and compares at the following falling edge. There it sweeps the combinational debug ports across one register and one memory word per cycle, and it also checks the program counter and all three flags. Named checks after each program cover the boundaries: the NOP-count restart, the exact program counter left at the fifth NOP, the illegal word, the out-of-range store, and a branch outside memory.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_BRCH  = 7'b1100011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  localparam int REG_COUNT = 32;
  localparam int XLEN      = 32;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2,
    ALU_AND = 2'd3
  } aluOp_e;

  typedef struct packed {
    logic   advance;     // instruction retires, pc moves
    logic   takeBranch;  // pc gets branch target
    logic   regWe;       // write rd
    logic   memWe;       // store rs2 to data address
    logic   wbMem;       // rd gets memory word instead of alu
    logic   aluImm;      // alu operand b is the I immediate
    aluOp_e aluOp;
  } ctrlStrobes_t;

endpackage

// File: rtl/mcore_control.sv
module mcore_control
  import mcore_pkg::*;
#(
  parameter int NOP_LIMIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [31:0]   inst,
  input  logic          rsEqual,
  input  logic          fetchBad,
  input  logic          dataAddrBad,
  output ctrlStrobes_t  strobes,
  output logic          done,
  output logic          illegal,
  output logic          memErr
);

  localparam int CNT_W = $clog2(NOP_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_FREE = CNT_W'(NOP_LIMIT - 1);

  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic [4:0] rdIdx;
  logic [4:0] rs1Idx;

  assign opcode = inst[6:0];
  assign rdIdx  = inst[11:7];
  assign funct3 = inst[14:12];
  assign rs1Idx = inst[19:15];
  assign funct7 = inst[31:25];

  logic isReg, isAddi, isBeq, isLoad, isStore, legal, isNop;
  aluOp_e aluSel;

  always_comb begin
    isReg   = 1'b0;
    isAddi  = (opcode == OPC_IMM)   && (funct3 == 3'b000);
    isBeq   = (opcode == OPC_BRCH)  && (funct3 == 3'b000);
    isLoad  = (opcode == OPC_LOAD)  && (funct3 == 3'b010);
    isStore = (opcode == OPC_STORE) && (funct3 == 3'b010);
    aluSel  = ALU_ADD;
    if (opcode == OPC_REG) begin
      unique case (funct3)
        3'b000: begin
          if (funct7 == 7'b0000000) begin
            isReg  = 1'b1;
            aluSel = ALU_ADD;
          end else if (funct7 == 7'b0100000) begin
            isReg  = 1'b1;
            aluSel = ALU_SUB;
          end
        end
        3'b110: begin
          isReg  = (funct7 == 7'b0000000);
          aluSel = ALU_OR;
        end
        3'b111: begin
          isReg  = (funct7 == 7'b0000000);
          aluSel = ALU_AND;
        end
        default: isReg = 1'b0;
      endcase
    end
    legal = isReg || isAddi || isBeq || isLoad || isStore;
    isNop = (opcode == OPC_IMM) && (funct3 == 3'b000) && (rdIdx == 5'd0)
            && (rs1Idx == 5'd0) && (inst[31:20] == 12'd0);
  end

  logic [CNT_W-1:0] nopCount;
  logic stopped, active;
  logic raiseDone, raiseIllegal, raiseMemErr, commit;

  assign stopped = done || illegal || memErr;
  assign active  = run && !stopped;

  always_comb begin
    raiseDone    = 1'b0;
    raiseIllegal = 1'b0;
    raiseMemErr  = 1'b0;
    commit       = 1'b0;
    if (active) begin
      if (fetchBad)
        raiseMemErr = 1'b1;
      else if (isNop && (nopCount == LAST_FREE))
        raiseDone = 1'b1;
      else if (!legal)
        raiseIllegal = 1'b1;
      else if ((isLoad || isStore) && dataAddrBad)
        raiseMemErr = 1'b1;
      else
        commit = 1'b1;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.advance    = commit;
    strobes.takeBranch = commit && isBeq && rsEqual;
    strobes.regWe      = commit && (isReg || isAddi || isLoad);
    strobes.memWe      = commit && isStore;
    strobes.wbMem      = isLoad;
    strobes.aluImm     = isAddi || isLoad;
    strobes.aluOp      = aluSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nopCount <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      memErr   <= 1'b0;
    end else begin
      if (raiseDone)    done    <= 1'b1;
      if (raiseIllegal) illegal <= 1'b1;
      if (raiseMemErr)  memErr  <= 1'b1;
      if (commit)
        nopCount <= isNop ? nopCount + 1'b1 : '0;
    end
  end

  AST_STOP_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, illegal, memErr})); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R8
  AST_NOP_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    nopCount < CNT_W'(NOP_LIMIT)); // R7
  AST_DONE_AFTER_NOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(nopCount) == LAST_FREE); // R7

endmodule

// File: rtl/mcore_datapath.sv
module mcore_datapath
  import mcore_pkg::*;
#(
  parameter int MEM_BYTES = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  ctrlStrobes_t         strobes,
  input  logic                 loadEn,
  input  logic [$clog2(MEM_BYTES/4)-1:0] loadIdx,
  input  logic [XLEN-1:0]      loadData,
  input  logic [4:0]           dbgRegSel,
  input  logic [$clog2(MEM_BYTES/4)-1:0] dbgMemIdx,
  output logic [XLEN-1:0]      inst,
  output logic                 rsEqual,
  output logic                 fetchBad,
  output logic                 dataAddrBad,
  output logic [XLEN-1:0]      dbgRegData,
  output logic [XLEN-1:0]      dbgMemData,
  output logic [XLEN-1:0]      pc
);

  localparam int MEM_WORDS = MEM_BYTES / 4;
  localparam int IDX_W     = $clog2(MEM_WORDS);
  localparam logic [XLEN-1:0] TOP_ADDR = XLEN'(MEM_BYTES - 1);

  logic [XLEN-1:0] regFile [REG_COUNT];
  logic [XLEN-1:0] mem     [MEM_WORDS];

  function automatic logic [XLEN-1:0] readReg(input logic [4:0] idx);
    return (idx == 5'd0) ? '0 : regFile[idx];
  endfunction

  logic [4:0] rdIdx, rs1Idx, rs2Idx;
  assign rdIdx  = inst[11:7];
  assign rs1Idx = inst[19:15];
  assign rs2Idx = inst[24:20];

  logic [XLEN-1:0] rs1Val, rs2Val;
  assign rs1Val = readReg(rs1Idx);
  assign rs2Val = readReg(rs2Idx);
  assign rsEqual = (rs1Val == rs2Val);

  // immediate generation
  logic [XLEN-1:0] immI, immS, immB;
  assign immI = {{20{inst[31]}}, inst[31:20]};
  assign immS = {{20{inst[31]}}, inst[31:25], inst[11:7]};
  assign immB = {{19{inst[31]}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};

  // fetch
  assign fetchBad = (pc > TOP_ADDR);
  assign inst     = mem[pc[IDX_W+1:2]];

  // data address: opcode bit 5 separates store from load
  logic [XLEN-1:0] dataAddr;
  assign dataAddr    = rs1Val + (inst[5] ? immS : immI);
  assign dataAddrBad = (dataAddr > TOP_ADDR);

  logic [XLEN-1:0] aluB, aluOut, wbData;
  assign aluB = strobes.aluImm ? immI : rs2Val;

  always_comb begin
    unique case (strobes.aluOp)
      ALU_ADD: aluOut = rs1Val + aluB;
      ALU_SUB: aluOut = rs1Val - aluB;
      ALU_OR:  aluOut = rs1Val | aluB;
      ALU_AND: aluOut = rs1Val & aluB;
      default: aluOut = rs1Val + aluB;
    endcase
  end

  assign wbData = strobes.wbMem ? mem[dataAddr[IDX_W+1:2]] : aluOut;

  logic [XLEN-1:0] pcNext;
  assign pcNext = strobes.takeBranch ? (pc + immB) : (pc + XLEN'(4));

  logic unusedLowBits;
  assign unusedLowBits = ^{dataAddr[1:0], rdIdx};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int r = 0; r < REG_COUNT; r++) regFile[r] <= '0;
    end else begin
      if (strobes.advance) pc <= pcNext;
      if (strobes.regWe && (rdIdx != 5'd0)) regFile[rdIdx] <= wbData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
    end else if (strobes.memWe) begin
      mem[dataAddr[IDX_W+1:2]] <= rs2Val;
    end else if (loadEn && !run) begin
      mem[loadIdx] <= loadData;
    end
  end

  assign dbgRegData = readReg(dbgRegSel);
  assign dbgMemData = mem[dbgMemIdx];

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.advance |=> $stable(pc)); // R8
  AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && !strobes.takeBranch) |=> pc == $past(pc) + XLEN'(4)); // R2
  AST_STORE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    strobes.memWe |-> !dataAddrBad); // R10
  AST_FETCH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |-> !fetchBad); // R10

endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int NOP_LIMIT = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        loadEn,
  input  logic [6:0]  loadIdx,
  input  logic [31:0] loadData,
  input  logic [4:0]  dbgRegSel,
  output logic [31:0] dbgRegData,
  input  logic [6:0]  dbgMemIdx,
  output logic [31:0] dbgMemData,
  output logic [31:0] dbgPc,
  output logic        done,
  output logic        illegal,
  output logic        memErr
);

  ctrlStrobes_t strobes;
  logic [31:0]  inst;
  logic         rsEqual, fetchBad, dataAddrBad;

  mcore_control #(.NOP_LIMIT(NOP_LIMIT)) uCtrl (
    .clk(clk), .rst(rst), .run(run), .inst(inst),
    .rsEqual(rsEqual), .fetchBad(fetchBad), .dataAddrBad(dataAddrBad),
    .strobes(strobes), .done(done), .illegal(illegal), .memErr(memErr)
  );

  mcore_datapath #(.MEM_BYTES(MEM_BYTES)) uDp (
    .clk(clk), .rst(rst), .run(run), .strobes(strobes),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .dbgRegSel(dbgRegSel), .dbgMemIdx(dbgMemIdx),
    .inst(inst), .rsEqual(rsEqual), .fetchBad(fetchBad),
    .dataAddrBad(dataAddrBad), .dbgRegData(dbgRegData),
    .dbgMemData(dbgMemData), .pc(dbgPc)
  );

endmodule

// File: tb/tb_mcore_top.sv
module tb_mcore_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        loadEn = 1'b0;
  logic [6:0]  loadIdx = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [6:0]  dbgMemIdx = '0;
  logic [31:0] dbgRegData, dbgMemData, dbgPc;
  logic        done, illegal, memErr;

  mcore_top dut (
    .clk(clk), .rst(rst), .run(run), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadData(loadData), .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemIdx(dbgMemIdx), .dbgMemData(dbgMemData), .dbgPc(dbgPc),
    .done(done), .illegal(illegal), .memErr(memErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int sweep = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  logic [31:0] mReg [32];
  logic [31:0] mMem [128];
  logic [31:0] mPc;
  int          mNops;
  bit          mDone, mIll, mErr;

  task automatic modelReset();
    foreach (mReg[i]) mReg[i] = 0;
    foreach (mMem[i]) mMem[i] = 0;
    mPc = 0; mNops = 0; mDone = 0; mIll = 0; mErr = 0;
  endtask

  function automatic logic [31:0] rv(input logic [4:0] n);
    return (n == 0) ? 32'd0 : mReg[n];
  endfunction

  task automatic modelStep();
    logic [31:0] w, a, b, ea, res;
    logic [12:0] boff;
    bit ok, wr;
    if (mPc > 511) begin mErr = 1; return; end
    w = mMem[mPc >> 2];
    if (w == 32'h00000013 && mNops == 4) begin mDone = 1; return; end
    a = rv(w[19:15]); b = rv(w[24:20]);
    ok = 0; wr = 0; res = 0;
    if (w[6:0] == 7'h33) begin
      if (w[14:12] == 0 && w[31:25] == 0)        begin ok = 1; res = a + b; end
      else if (w[14:12] == 0 && w[31:25] == 32)  begin ok = 1; res = a - b; end
      else if (w[14:12] == 6 && w[31:25] == 0)   begin ok = 1; res = a | b; end
      else if (w[14:12] == 7 && w[31:25] == 0)   begin ok = 1; res = a & b; end
      wr = ok;
    end else if (w[6:0] == 7'h13 && w[14:12] == 0) begin
      ok = 1; wr = 1; res = a + 32'($signed(w[31:20]));
    end else if (w[6:0] == 7'h03 && w[14:12] == 2) begin
      ea = a + 32'($signed(w[31:20]));
      if (ea > 511) begin mErr = 1; return; end
      ok = 1; wr = 1; res = mMem[ea >> 2];
    end else if (w[6:0] == 7'h23 && w[14:12] == 2) begin
      ea = a + 32'($signed({w[31:25], w[11:7]}));
      if (ea > 511) begin mErr = 1; return; end
      ok = 1; mMem[ea >> 2] = b;
    end else if (w[6:0] == 7'h63 && w[14:12] == 0) begin
      ok = 1;
    end
    if (!ok) begin mIll = 1; return; end
    if (wr && w[11:7] != 0) mReg[w[11:7]] = res;
    if (w[6:0] == 7'h63 && a == b) begin
      boff = {w[31], w[7], w[30:25], w[11:8], 1'b0};
      mPc = mPc + 32'($signed(boff));
    end else begin
      mPc = mPc + 4;
    end
    mNops = (w == 32'h00000013) ? mNops + 1 : 0;
  endtask

  task automatic modelEdge();
    if (rst) modelReset();
    else if (run) begin
      if (!(mDone || mIll || mErr)) modelStep();
    end else if (loadEn) mMem[loadIdx] = loadData;
  endtask

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic peekReg(input int n, output logic [31:0] v);
    dbgRegSel = 5'(n); #1; v = dbgRegData;
  endtask

  task automatic peekMem(input int n, output logic [31:0] v);
    dbgMemIdx = 7'(n); #1; v = dbgMemData;
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    dbgRegSel = 5'(sweep % 32);
    dbgMemIdx = 7'(sweep % 128);
    #1;
    check("R2 pc vs model", dbgPc, mPc);
    check("R7 done vs model", 32'(done), 32'(mDone));
    check("R9 illegal vs model", 32'(illegal), 32'(mIll));
    check("R10 memErr vs model", 32'(memErr), 32'(mErr));
    check("R3 register sweep", dbgRegData, mReg[sweep % 32]);
    check("R5 memory sweep", dbgMemData, mMem[sweep % 128]);
    sweep++;
  endtask

  task automatic doReset();
    run = 0; loadEn = 0; rst = 1;
    tick(); tick();
    rst = 0;
  endtask

  task automatic loadProgram(input logic [31:0] prog[$]);
    run = 0;
    foreach (prog[i]) begin
      loadEn = 1; loadIdx = 7'(i); loadData = prog[i];
      tick();
    end
    loadEn = 0;
  endtask

  task automatic runProgram(input int cap);
    run = 1;
    for (int k = 0; k < cap; k++) begin
      tick();
      if (done || illegal || memErr) break;
    end
  endtask

  // ---------------- encoders ----------------
  function automatic logic [31:0] encR(input logic [6:0] f7, input int rs2, input int rs1,
                                       input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] encAddi(input int rd, input int rs1, input int imm);
    return {12'(imm), 5'(rs1), 3'b000, 5'(rd), 7'b0010011};
  endfunction
  function automatic logic [31:0] encLw(input int rd, input int rs1, input int imm);
    return {12'(imm), 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] encSw(input int rs2, input int rs1, input int imm);
    logic [11:0] m;
    m = 12'(imm);
    return {m[11:5], 5'(rs2), 5'(rs1), 3'b010, m[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] encBeq(input int rs1, input int rs2, input int off);
    logic [12:0] o;
    o = 13'(off);
    return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'b000, o[4:1], o[11], 7'b1100011};
  endfunction

  localparam logic [31:0] NOP = 32'h00000013;

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      mismatched++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] v;
    logic [31:0] prog[$];

    // R1: reset state
    doReset();
    check("R1 pc after reset", dbgPc, 32'd0);
    check("R1 flags after reset", {29'd0, done, illegal, memErr}, 32'd0);
    peekReg(9, v);  check("R1 register zero", v, 32'd0);
    peekMem(77, v); check("R1 memory zero", v, 32'd0);

    // fibonacci program
    prog = {};
    prog.push_back(encAddi(5, 0, 10));
    prog.push_back(encAddi(4, 0, 0));
    prog.push_back(encAddi(1, 0, 0));
    prog.push_back(encAddi(2, 0, 1));
    prog.push_back(encBeq(4, 5, 24));
    prog.push_back(encR(7'h00, 2, 1, 3'b000, 3));
    prog.push_back(encR(7'h00, 0, 2, 3'b000, 1));
    prog.push_back(encR(7'h00, 0, 3, 3'b000, 2));
    prog.push_back(encAddi(4, 4, 1));
    prog.push_back(encBeq(0, 0, -20));
    prog.push_back(encAddi(6, 0, 256));
    prog.push_back(encSw(1, 6, 0));
    repeat (5) prog.push_back(NOP);
    loadProgram(prog);

    // R11: no stepping while run is low, load readable
    tick(); tick(); tick();
    check("R11 pc holds while run low", dbgPc, 32'd0);
    peekMem(4, v); check("R11 loaded word", v, encBeq(4, 5, 24));

    runProgram(400);
    check("R7 done after five nops", 32'(done), 32'd1);
    check("R7 pc left at fifth nop", dbgPc, 32'd64);
    peekReg(1, v);  check("R3 fib(10) in x1", v, 32'd55);
    peekReg(4, v);  check("R2 loop count via beq", v, 32'd10);
    peekMem(64, v); check("R5 sw result at 0x100", v, 32'd55);

    // R8: frozen after stop with run high
    repeat (8) tick();
    check("R8 pc frozen", dbgPc, 32'd64);
    peekReg(2, v); check("R8 register frozen", v, 32'd89);

    // arithmetic, x0, memory and nop-restart program
    doReset();
    prog = {};
    prog.push_back(encAddi(1, 0, -7));
    prog.push_back(encAddi(2, 0, 12));
    prog.push_back(encR(7'h20, 2, 1, 3'b000, 3));
    prog.push_back(encR(7'h00, 2, 1, 3'b110, 4));
    prog.push_back(encR(7'h00, 2, 1, 3'b111, 5));
    prog.push_back(encAddi(0, 1, 5));
    prog.push_back(encR(7'h00, 2, 1, 3'b000, 0));
    prog.push_back(encAddi(6, 0, 260));
    prog.push_back(encSw(3, 6, -4));
    prog.push_back(encLw(7, 0, 256));
    prog.push_back(encBeq(1, 2, 8));
    repeat (4) prog.push_back(NOP);
    prog.push_back(encAddi(8, 0, 1));
    repeat (5) prog.push_back(NOP);
    loadProgram(prog);
    runProgram(100);
    peekReg(1, v); check("R4 addi negative immediate", v, 32'hFFFFFFF9);
    peekReg(3, v); check("R3 sub", v, 32'hFFFFFFED);
    peekReg(4, v); check("R3 or", v, 32'hFFFFFFFD);
    peekReg(5, v); check("R3 and", v, 32'h00000008);
    peekReg(0, v); check("R6 x0 stays zero", v, 32'd0);
    peekMem(64, v); check("R5 sw negative offset", v, 32'hFFFFFFED);
    peekReg(7, v); check("R5 lw", v, 32'hFFFFFFED);
    peekReg(8, v); check("R7 instruction between nop runs", v, 32'd1);
    check("R7 count restarted, pc at fifth nop", dbgPc, 32'd80);
    check("R7 done set", 32'(done), 32'd1);

    // R9: illegal encoding
    doReset();
    prog = {};
    prog.push_back(encAddi(1, 0, 3));
    prog.push_back(encR(7'h01, 2, 1, 3'b000, 3));
    prog.push_back(encAddi(1, 0, 9));
    loadProgram(prog);
    runProgram(20);
    check("R9 illegal raised", 32'(illegal), 32'd1);
    check("R9 pc at illegal word", dbgPc, 32'd4);
    peekReg(3, v); check("R9 no write", v, 32'd0);
    repeat (3) tick();
    peekReg(1, v); check("R8 no later execution", v, 32'd3);

    // R10: store just past the end
    doReset();
    prog = {};
    prog.push_back(encAddi(1, 0, 508));
    prog.push_back(encSw(1, 1, 4));
    loadProgram(prog);
    runProgram(20);
    check("R10 memErr on store to 512", 32'(memErr), 32'd1);
    check("R10 pc at faulting store", dbgPc, 32'd4);
    peekMem(0, v); check("R10 no aliased write", v, encAddi(1, 0, 508));

    // R10: fetch out of range after branch
    doReset();
    prog = {};
    prog.push_back(encBeq(0, 0, 1000));
    loadProgram(prog);
    runProgram(20);
    check("R10 memErr on fetch beyond memory", 32'(memErr), 32'd1);
    check("R10 pc after far branch", dbgPc, 32'd1000);

    // R10: load with wrapped negative address
    doReset();
    prog = {};
    prog.push_back(encAddi(1, 0, -4));
    prog.push_back(encLw(2, 1, 0));
    loadProgram(prog);
    runProgram(20);
    check("R10 memErr on negative load", 32'(memErr), 32'd1);
    peekReg(2, v); check("R10 no load writeback", v, 32'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule